// File: doc/BRIEF.md
# Bidirectional Cascaded Pixel Load Sequencer

This block fills a line register of 140 pixel slots, each holding one 18-bit word made of three 6-bit colour channels, so one line covers 420 sub-pixel channels. A load starts when a start pulse arrives on one of two bidirectional pins. A direction strap decides which pin takes the start pulse and which pin carries the hand-off pulse to the next chip in a cascade. The strap also decides whether slots fill from the low end or from the high end.

All events happen on the rising edge of `clk`, which the system derives from the inverted shift clock. The first edge that sees the start pin high arms the sequencer. Pixels are stored from the second edge onward, one per edge on which `pix_valid` is high. When the last slot is written, the sequencer drops `busy`, pulses the carry pin for one clock and then ignores pixels until a new start pulse arrives.

In a cascade, the carry pin of one chip drives the start pin of the next chip, and all other inputs are shared. Moving the finished line into the output stage is outside this block.

Top module: `pixel_load_seq`

## Requirements
- R1: While `rst_n` is low, `busy`, both carry outputs and both output enables are 0, and every line slot reads 0.
- R2: With `dir_fwd`=1, pin A is the start input and never drives (`sp_a_oe`=0), and pin B drives after reset. The k-th stored pixel goes to slot k (0 to 139).
- R3: With `dir_fwd`=0, pin B is the start input and never drives (`sp_b_oe`=0), and pin A drives after reset. The k-th stored pixel goes to slot 139-k.
- R4: A rising start input seen on a clock edge sets `busy` after that edge. The pixel offered on that same edge is not stored. The first pixel is stored on the next edge.
- R5: A start pulse one or two clocks wide arms the sequencer once. While the second high cycle lasts, pixels are stored normally.
- R6: An edge with `pix_valid`=0 during loading stores nothing and does not advance the slot position.
- R7: On the edge that stores the 140th pixel, `busy` falls. After that, pixels leave the line unchanged until the next start pulse.
- R8: On the edge that stores the 140th pixel, the output-pin carry rises, and it falls on the next edge, so it is high for exactly one clock.
- R9: A start rise during loading restarts the load at the first position. The pixel offered on that edge is not stored.
- R10: Slot s occupies `line_o[18*s+17 : 18*s]` and holds `pix_data` unchanged: bits 5:0 are the first colour, 11:6 the second and 17:12 the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (rising edge active) |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_fwd | input | 1 | Direction strap: 1 = start on A, ascending fill |
| sp_a_in | input | 1 | Pin A input value |
| sp_a_out | output | 1 | Pin A drive value (carry) |
| sp_a_oe | output | 1 | Pin A output enable |
| sp_b_in | input | 1 | Pin B input value |
| sp_b_out | output | 1 | Pin B drive value (carry) |
| sp_b_oe | output | 1 | Pin B output enable |
| pix_data | input | 18 | Pixel word, three 6-bit colours |
| pix_valid | input | 1 | Pixel strobe |
| line_o | output | 2520 | Line register, 140 slots of 18 bits |
| busy | output | 1 | 1 while loading, 0 in standby |

## Verification
- Arming takes one edge: `busy` rises on the edge that sees the start rise. The first pixel lands in the line one edge later.
- The carry pin and the drop of `busy` both appear on the edge that stores the final pixel. The carry clears on the following edge.
- The bench's reference model steps on the same rising edge as the design. The bench compares all outputs 3 ns after every rising edge, so every registered result is settled and no input has yet moved.
- Directed checks sample at those same points, right after the arming edge, the final-store edge and the edge after it.

// File: rtl/sld_pkg.sv
package sld_pkg;
  typedef enum logic {
    ST_STANDBY = 1'b0,
    ST_FILL    = 1'b1
  } fill_state_e;
endpackage

// File: rtl/sld_pin_steer.sv
module sld_pin_steer (
  input  logic dir_fwd,
  input  logic drive_en,
  input  logic carry,
  input  logic sp_a_in,
  input  logic sp_b_in,
  output logic start_sel,
  output logic sp_a_out,
  output logic sp_a_oe,
  output logic sp_b_out,
  output logic sp_b_oe
);
  always_comb begin
    start_sel = dir_fwd ? sp_a_in : sp_b_in;
    sp_a_oe   = drive_en & ~dir_fwd;
    sp_b_oe   = drive_en & dir_fwd;
    sp_a_out  = carry & sp_a_oe;
    sp_b_out  = carry & sp_b_oe;
  end
endmodule

// File: rtl/sld_start_edge.sv
module sld_start_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic start_sel,
  output logic start_rise,
  output logic drive_en
);
  logic prev_q;
  logic drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      prev_q <= start_sel;
      drv_q  <= 1'b1;
    end
  end

  assign start_rise = start_sel & ~prev_q;
  assign drive_en   = drv_q;
endmodule

// File: rtl/sld_fill_ctrl.sv
module sld_fill_ctrl #(
  parameter int POSITIONS = 140,
  localparam int CNT_W = $clog2(POSITIONS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_fwd,
  input  logic             start_rise,
  input  logic             pix_valid,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_slot,
  output logic             busy,
  output logic             carry
);
  import sld_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(POSITIONS - 1);

  fill_state_e      state_q, state_d;
  logic [CNT_W-1:0] pos_q, pos_d;
  logic             carry_q, carry_d;

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    carry_d = 1'b0;
    wr_en   = 1'b0;
    if (start_rise) begin
      state_d = ST_FILL;
      pos_d   = '0;
    end else if (state_q == ST_FILL && pix_valid) begin
      wr_en = 1'b1;
      if (pos_q == LAST) begin
        state_d = ST_STANDBY;
        pos_d   = '0;
        carry_d = 1'b1;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_STANDBY;
      pos_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      carry_q <= carry_d;
    end
  end

  assign wr_slot = dir_fwd ? pos_q : (LAST - pos_q);
  assign busy    = (state_q == ST_FILL);
  assign carry   = carry_q;
endmodule

// File: rtl/sld_line_store.sv
module sld_line_store #(
  parameter int POSITIONS = 140,
  parameter int PIX_W = 18,
  localparam int CNT_W = $clog2(POSITIONS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [CNT_W-1:0]           wr_slot,
  input  logic [PIX_W-1:0]           wr_data,
  output logic [POSITIONS*PIX_W-1:0] line_o
);
  for (genvar g = 0; g < POSITIONS; g++) begin : g_slot
    logic [PIX_W-1:0] slot_q;
    logic             slot_we;
    assign slot_we = wr_en && (wr_slot == CNT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_we) slot_q <= wr_data;
    end
    assign line_o[g*PIX_W +: PIX_W] = slot_q;
  end
endmodule

// File: rtl/pixel_load_seq.sv
module pixel_load_seq #(
  parameter int POSITIONS = 140,
  parameter int PIX_W = 18,
  localparam int CNT_W = $clog2(POSITIONS),
  localparam int LINE_W = POSITIONS * PIX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_fwd,
  input  logic              sp_a_in,
  output logic              sp_a_out,
  output logic              sp_a_oe,
  input  logic              sp_b_in,
  output logic              sp_b_out,
  output logic              sp_b_oe,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              pix_valid,
  output logic [LINE_W-1:0] line_o,
  output logic              busy
);
  logic             start_sel;
  logic             start_rise;
  logic             drive_en;
  logic             carry;
  logic             wr_en;
  logic [CNT_W-1:0] wr_slot;

  sld_pin_steer u_steer (
    .dir_fwd   (dir_fwd),
    .drive_en  (drive_en),
    .carry     (carry),
    .sp_a_in   (sp_a_in),
    .sp_b_in   (sp_b_in),
    .start_sel (start_sel),
    .sp_a_out  (sp_a_out),
    .sp_a_oe   (sp_a_oe),
    .sp_b_out  (sp_b_out),
    .sp_b_oe   (sp_b_oe)
  );

  sld_start_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_sel  (start_sel),
    .start_rise (start_rise),
    .drive_en   (drive_en)
  );

  sld_fill_ctrl #(.POSITIONS(POSITIONS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir_fwd    (dir_fwd),
    .start_rise (start_rise),
    .pix_valid  (pix_valid),
    .wr_en      (wr_en),
    .wr_slot    (wr_slot),
    .busy       (busy),
    .carry      (carry)
  );

  sld_line_store #(.POSITIONS(POSITIONS), .PIX_W(PIX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_slot (wr_slot),
    .wr_data (pix_data),
    .line_o  (line_o)
  );
endmodule

// File: rtl/sld_checker.sv
module sld_checker #(
  parameter int LINE_W = 2520
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dir_fwd,
  input logic              sp_a_in,
  input logic              sp_b_in,
  input logic              sp_a_out,
  input logic              sp_b_out,
  input logic              sp_a_oe,
  input logic              sp_b_oe,
  input logic              busy,
  input logic [LINE_W-1:0] line_o
);
  logic prev_sel_q;
  logic sel;
  logic carry_any;

  assign sel       = dir_fwd ? sp_a_in : sp_b_in;
  assign carry_any = sp_a_out | sp_b_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_sel_q <= 1'b0;
    else        prev_sel_q <= sel;
  end

  p_carry_one_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    carry_any |=> !carry_any);

  p_carry_means_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
    carry_any |-> !busy);

  p_fwd_start_pin_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dir_fwd |-> !sp_a_oe);

  p_rev_start_pin_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_fwd |-> !sp_b_oe);

  p_standby_holds_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(line_o));

  p_start_arms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !prev_sel_q) |=> busy);

  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (!busy && !sp_a_oe && !sp_b_oe && !carry_any);
    end
  end
endmodule

bind pixel_load_seq sld_checker #(.LINE_W(LINE_W)) u_sld_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .dir_fwd  (dir_fwd),
  .sp_a_in  (sp_a_in),
  .sp_b_in  (sp_b_in),
  .sp_a_out (sp_a_out),
  .sp_b_out (sp_b_out),
  .sp_a_oe  (sp_a_oe),
  .sp_b_oe  (sp_b_oe),
  .busy     (busy),
  .line_o   (line_o)
);

// File: tb/test_pixel_load_seq.sv
`timescale 1ns/1ps
module test_pixel_load_seq;
  localparam int NPOS = 140;
  localparam int PW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_fwd = 1'b1;
  logic sp_a_in = 1'b0;
  logic sp_b_in = 1'b0;
  logic [PW-1:0] pix = '0;
  logic pix_valid = 1'b0;
  logic sp_a_out, sp_a_oe, sp_b_out, sp_b_oe, busy;
  logic [NPOS*PW-1:0] line_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pixel_load_seq i_pixel_load_seq (
    .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd),
    .sp_a_in(sp_a_in), .sp_a_out(sp_a_out), .sp_a_oe(sp_a_oe),
    .sp_b_in(sp_b_in), .sp_b_out(sp_b_out), .sp_b_oe(sp_b_oe),
    .pix_data(pix), .pix_valid(pix_valid), .line_o(line_o), .busy(busy)
  );

  // behavioural reference
  bit m_busy, m_carry, m_prev, m_drive;
  int m_cnt;
  logic [PW-1:0] m_slot [NPOS];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_carry = 0; m_prev = 0; m_drive = 0; m_cnt = 0;
      for (int i = 0; i < NPOS; i++) m_slot[i] = '0;
    end else begin
      bit s;
      s = dir_fwd ? sp_a_in : sp_b_in;
      m_carry = 0;
      m_drive = 1;
      if (s && !m_prev) begin
        m_busy = 1; m_cnt = 0;
      end else if (m_busy && pix_valid) begin
        m_slot[dir_fwd ? m_cnt : NPOS-1-m_cnt] = pix;
        m_cnt++;
        if (m_cnt == NPOS) begin m_busy = 0; m_carry = 1; m_cnt = 0; end
      end
      m_prev = s;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [PW-1:0] slot(input int s);
    return line_o[s*PW +: PW];
  endfunction

  // per-cycle comparison, 3 ns after each active edge
  always @(posedge clk) begin
    #3;
    if (!done) begin
      bit a_oe_e, b_oe_e;
      a_oe_e = m_drive && !dir_fwd;
      b_oe_e = m_drive && dir_fwd;
      chk(busy == m_busy, "R4/R7 busy", busy, m_busy);
      chk(sp_a_oe == a_oe_e && sp_b_oe == b_oe_e, "R2/R3 pin enables",
          {sp_a_oe, sp_b_oe}, {a_oe_e, b_oe_e});
      chk(sp_a_out == (m_carry && a_oe_e) && sp_b_out == (m_carry && b_oe_e), "R8 carry",
          {sp_a_out, sp_b_out}, {m_carry && a_oe_e, m_carry && b_oe_e});
      for (int i = 0; i < NPOS; i++) begin
        if (slot(i) !== m_slot[i]) begin
          chk(0, $sformatf("R10 slot %0d", i), slot(i), m_slot[i]);
          break;
        end
      end
    end
  end

  task automatic cyc(input bit a, input bit b, input logic [PW-1:0] d, input bit v);
    @(negedge clk);
    sp_a_in = a; sp_b_in = b; pix = d; pix_valid = v;
  endtask

  function automatic logic [PW-1:0] pv(input int k, input int seed);
    return PW'(k * 37 + seed * 1111 + 5);
  endfunction

  task automatic settle();
    @(posedge clk); #3;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !sp_a_oe && !sp_b_oe && line_o == '0, "R1 reset state",
        {busy, sp_a_oe, sp_b_oe}, 0);
    rst_n = 1'b1;
    settle();
    chk(sp_b_oe && !sp_a_oe, "R2 output pin after reset", {sp_a_oe, sp_b_oe}, 2'b01);

    // A: ascending, 1-wide start, gaps, overflow pixels
    dir_fwd = 1'b1;
    cyc(1, 0, 18'h3FFFF, 1);
    settle();
    chk(busy, "R4 armed after start edge", busy, 1);
    for (int k = 0; k < NPOS; k++) begin
      if (k % 17 == 5) cyc(0, 0, 18'h2AAAA, 0);
      cyc(0, 0, pv(k, 1), 1);
    end
    settle();
    chk(sp_b_out && !busy, "R8 carry on final edge", {sp_b_out, busy}, 2'b10);
    cyc(0, 0, 18'h15555, 1);
    settle();
    chk(!sp_b_out, "R8 carry one clock", sp_b_out, 0);
    cyc(0, 0, 18'h15555, 1);
    cyc(0, 0, 18'h0, 0);
    settle();
    chk(slot(0) == pv(0, 1), "R4 first pixel in slot 0", slot(0), pv(0, 1));
    chk(slot(6) == pv(6, 1), "R6 gap did not advance", slot(6), pv(6, 1));
    chk(slot(139) == pv(139, 1) && !busy, "R7 last slot, standby ignores pixels",
        slot(139), pv(139, 1));
    chk(slot(7)[5:0] == pv(7, 1) % 64, "R10 first colour bits", slot(7)[5:0], pv(7, 1) % 64);

    // B: descending, 2-wide start on pin B
    dir_fwd = 1'b0;
    cyc(0, 1, 18'h3FFFF, 1);
    cyc(0, 1, pv(0, 2), 1);
    for (int k = 1; k < NPOS; k++) cyc(0, 0, pv(k, 2), 1);
    settle();
    chk(sp_a_out && sp_a_oe && !sp_b_oe, "R3 carry on pin A", {sp_a_out, sp_b_oe}, 2'b10);
    cyc(0, 0, 18'h0, 0);
    settle();
    chk(slot(139) == pv(0, 2), "R3 first pixel in top slot", slot(139), pv(0, 2));
    chk(slot(0) == pv(139, 2), "R5 two-wide pulse armed once", slot(0), pv(139, 2));

    // C: ascending, restart mid-line
    dir_fwd = 1'b1;
    cyc(0, 0, 18'h0, 0);
    cyc(1, 0, 18'h0, 0);
    for (int k = 0; k < 20; k++) cyc(0, 0, pv(k, 3), 1);
    cyc(1, 0, 18'h12345, 1);
    for (int k = 0; k < NPOS; k++) cyc(0, 0, pv(k, 4), 1);
    cyc(0, 0, 18'h0, 0);
    settle();
    chk(slot(0) == pv(0, 4), "R9 restart from first slot", slot(0), pv(0, 4));
    chk(slot(20) == pv(20, 4), "R9 restart pixel dropped", slot(20), pv(20, 4));

    // D: start on the output pin is ignored
    cyc(0, 1, 18'h0, 0);
    cyc(0, 0, 18'h01234, 1);
    cyc(0, 0, 18'h01234, 1);
    cyc(0, 0, 18'h0, 0);
    settle();
    chk(!busy && slot(0) == pv(0, 4), "R2 pin B start ignored", slot(0), pv(0, 4));

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule